// File: doc/BRIEF.md
# Status LED Pattern Generator

This block drives two indicator LEDs for a board controller. One is the status LED; the other is the user LED. Each clock, the block looks at a set of inputs: the external reset request, the power enable, whether the main rails are up, whether the processor reset has been released, and the boot source that was latched at power-on. From these it picks one of several light codes. Each code differs in frequency or duty cycle, so an observer can read the power state and the boot source from the status LED alone.

All blink waveforms come from one free-running timebase. A prescaler divides the system clock down to a tick of `TICK_HZ` (16 Hz by default). A 5-bit phase counter advances on each tick, so its full cycle lasts 32 ticks, which is 2 s. Every pattern is a decode of this single phase, so the patterns stay aligned and the output switches cleanly when the state changes.

Once the processor is out of reset, a 4-bit selector written by software can move the user LED away from its default GPIO source onto one of the network PHY activity signals. Both LED outputs are registered. Each output therefore shows the inputs and the phase from the previous clock.

Top module: `led_pattern_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, both LED outputs become 0 and the timebase phase returns to 0. After release, the phase advances by one every `CLK_HZ/TICK_HZ` clocks and wraps after 32 ticks. Both outputs reflect the inputs and the phase one clock later.
- R2: When `resin_n` is low, both LEDs are on (1). This takes priority over every other condition.
- R3: When `resin_n` is high and `pwr_en` is low, the user LED is on. The status LED is on for phases 0 to 3 of each 32-tick period, which is 1/8 duty at 0.5 Hz.
- R4: When `pwr_en` is high and `rails_good` is low, the status LED is solid on and the user LED is off.
- R5: When running (`resin_n`, `pwr_en` and `rails_good` all high) with `boot_sd` = 0, which means SPI flash boot, the status LED is on when phase bit 1 is 0. This gives a 4 Hz blink at 50 % duty.
- R6: When running with `boot_sd` = 1, which means SD card boot, the status LED is on when phase bit 3 is 0. This gives a 1 Hz blink at 50 % duty.
- R7: When running with `por_done` low, the user LED follows `gpio_led`, whatever the value of `led_sel`.
- R8: When running with `por_done` high, the user LED follows a source chosen by `led_sel`: 4'b0000 selects `gpio_led`, 4'b0001 selects `phy_led0` and 4'b0010 selects `phy_led1`.
- R9: When running with `por_done` high, any `led_sel` value from 4'b0011 to 4'b1111 selects `gpio_led`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| resin_n | input | 1 | External reset request, active low |
| pwr_en | input | 1 | Power enable request |
| rails_good | input | 1 | Main supply rails are up |
| por_done | input | 1 | Processor reset has been released |
| boot_sd | input | 1 | Latched boot source: 1 = SD card, 0 = SPI flash |
| led_sel | input | 4 | Software remap selector for the user LED |
| gpio_led | input | 1 | Default processor GPIO LED source |
| phy_led0 | input | 1 | PHY activity signal 0 |
| phy_led1 | input | 1 | PHY activity signal 1 |
| led_status | output | 1 | Status LED drive, 1 = on |
| led_user | output | 1 | User LED drive, 1 = on |

## Verification
Two things can land on the same clock edge: a change of state (priority mode or remap selection) and a tick that moves the phase across a pattern edge. Either can alter the next output value. The bench changes inputs at random intervals of one to eight cycles while the tick runs every four clocks, so state changes keep hitting tick boundaries and phase-pattern edges. In every cycle, the bench takes the phase it expects from the count of clocks since reset, combines it with the inputs held before that edge, and compares the result with both LED outputs. This covers the selector changing in the same cycle that `por_done` rises, and a mid-run reset that must restart the phase.

// File: rtl/led_pkg.sv
// Package: shared types and constants for the status LED pattern generator.
// Assumes a fixed 5-bit phase: 32 ticks per slowest pattern period.
package led_pkg;

    localparam int PHASE_W = 5;

    // Priority-resolved operating condition
    typedef enum logic [1:0] {
        MODE_RESET    = 2'd0,
        MODE_PWRDN    = 2'd1,
        MODE_RAILSOFF = 2'd2,
        MODE_RUN      = 2'd3
    } led_mode_t;

    // User LED source encodings
    localparam logic [3:0] SEL_GPIO = 4'b0000;
    localparam logic [3:0] SEL_PHY0 = 4'b0001;
    localparam logic [3:0] SEL_PHY1 = 4'b0010;

endpackage

// File: rtl/led_timebase.sv
// Module: led_timebase
// Divides the system clock into ticks and counts ticks into a wrapping phase.
// Assumes DIV >= 2. Phase and prescaler both clear on synchronous reset.
module led_timebase #(
    parameter int DIV     = 4,
    parameter int PHASE_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [PHASE_W-1:0] phase
);
    localparam int PRE_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(DIV - 1);

    logic [PRE_W-1:0] pre_q;

    // Prescaler and phase counter: phase steps once per DIV clocks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            phase <= '0;
        end else if (pre_q == PRE_LAST) begin
            pre_q <= '0;
            phase <= phase + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/led_mode_decode.sv
// Module: led_mode_decode
// Resolves the control inputs into one operating mode by fixed priority:
// external reset, then power-down, then rails-off, then running.
module led_mode_decode
    import led_pkg::*;
(
    input  logic      resin_n,
    input  logic      pwr_en,
    input  logic      rails_good,
    output led_mode_t mode
);
    // Priority resolution of the operating condition
    always_comb begin
        if (!resin_n)         mode = MODE_RESET;
        else if (!pwr_en)     mode = MODE_PWRDN;
        else if (!rails_good) mode = MODE_RAILSOFF;
        else                  mode = MODE_RUN;
    end
endmodule

// File: rtl/led_user_mux.sv
// Module: led_user_mux
// Chooses the user LED source in the running mode. Keeps the default GPIO
// source until the processor is out of reset; undefined selectors fall back.
module led_user_mux
    import led_pkg::*;
(
    input  logic       por_done,
    input  logic [3:0] led_sel,
    input  logic       gpio_led,
    input  logic       phy_led0,
    input  logic       phy_led1,
    output logic       user_src
);
    // Remap selection with default fallback
    always_comb begin
        user_src = gpio_led;
        if (por_done) begin
            case (led_sel)
                SEL_PHY0: user_src = phy_led0;
                SEL_PHY1: user_src = phy_led1;
                default:  user_src = gpio_led;
            endcase
        end
    end
endmodule

// File: rtl/led_pattern_gen.sv
// Module: led_pattern_gen (top)
// Drives the status and user LEDs from the controller state. All blink codes
// are decoded from one shared phase; outputs are registered, so they show
// the previous cycle's inputs and phase.
// Assumes CLK_HZ is an integer multiple of TICK_HZ, at least 2x.
module led_pattern_gen
    import led_pkg::*;
#(
    parameter int CLK_HZ  = 50_000_000,
    parameter int TICK_HZ = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       resin_n,
    input  logic       pwr_en,
    input  logic       rails_good,
    input  logic       por_done,
    input  logic       boot_sd,
    input  logic [3:0] led_sel,
    input  logic       gpio_led,
    input  logic       phy_led0,
    input  logic       phy_led1,
    output logic       led_status,
    output logic       led_user
);
    localparam int DIV = CLK_HZ / TICK_HZ;

    logic [PHASE_W-1:0] phase;
    led_mode_t          mode;
    logic               user_src;
    logic               fast_on, slow_on, pwrdn_on;
    logic               status_d, user_d;

    led_timebase #(.DIV(DIV), .PHASE_W(PHASE_W)) u_tb (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase)
    );

    led_mode_decode u_mode (
        .resin_n    (resin_n),
        .pwr_en     (pwr_en),
        .rails_good (rails_good),
        .mode       (mode)
    );

    led_user_mux u_mux (
        .por_done (por_done),
        .led_sel  (led_sel),
        .gpio_led (gpio_led),
        .phy_led0 (phy_led0),
        .phy_led1 (phy_led1),
        .user_src (user_src)
    );

    // Pattern decodes from the shared phase
    always_comb begin
        fast_on  = ~phase[1];
        slow_on  = ~phase[3];
        pwrdn_on = (phase[PHASE_W-1:2] == '0);
    end

    // Per-mode selection of the next LED levels
    always_comb begin
        case (mode)
            MODE_RESET:    begin status_d = 1'b1;     user_d = 1'b1;     end
            MODE_PWRDN:    begin status_d = pwrdn_on; user_d = 1'b1;     end
            MODE_RAILSOFF: begin status_d = 1'b1;     user_d = 1'b0;     end
            default:       begin
                status_d = boot_sd ? slow_on : fast_on;
                user_d   = user_src;
            end
        endcase
    end

    // Output registers for glitch-free LED drive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            led_status <= 1'b0;
            led_user   <= 1'b0;
        end else begin
            led_status <= status_d;
            led_user   <= user_d;
        end
    end
endmodule

// File: rtl/led_pattern_chk.sv
// Module: led_pattern_chk
// Port-level properties of led_pattern_gen, attached by bind below.
module led_pattern_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       resin_n,
    input logic       pwr_en,
    input logic       rails_good,
    input logic       por_done,
    input logic [3:0] led_sel,
    input logic       gpio_led,
    input logic       phy_led0,
    input logic       led_status,
    input logic       led_user
);
    logic run;
    assign run = resin_n && pwr_en && rails_good;

    p_reset_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !resin_n |=> (led_status && led_user));

    p_rails_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (resin_n && pwr_en && !rails_good) |=> (led_status && !led_user));

    p_default_before_boot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !por_done) |=> (led_user == $past(gpio_led)));

    p_map_phy0_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && por_done && led_sel == 4'b0001) |=> (led_user == $past(phy_led0)));

    p_undef_fallback_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && por_done && led_sel > 4'b0010) |=> (led_user == $past(gpio_led)));

    p_pwrdn_user_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (resin_n && !pwr_en) |=> led_user);
endmodule

bind led_pattern_gen led_pattern_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .resin_n    (resin_n),
    .pwr_en     (pwr_en),
    .rails_good (rails_good),
    .por_done   (por_done),
    .led_sel    (led_sel),
    .gpio_led   (gpio_led),
    .phy_led0   (phy_led0),
    .led_status (led_status),
    .led_user   (led_user)
);

// File: tb/led_pattern_gen_tb.sv
// Bench for led_pattern_gen: seeded random stimulus plus directed corners,
// compared every cycle against expected values from bench functions.
module led_pattern_gen_tb;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       resin_n = 1'b1, pwr_en = 1'b1, rails_good = 1'b1;
    logic       por_done = 1'b0, boot_sd = 1'b0;
    logic [3:0] led_sel = 4'd0;
    logic       gpio_led = 1'b0, phy_led0 = 1'b0, phy_led1 = 1'b0;
    logic       led_status, led_user;

    int  checks = 0, errors = 0;
    int  ecount = 0;
    bit  done = 1'b0;
    logic exp_s, exp_u;
    string exp_tag;

    always #10 clk = ~clk;  // 50 MHz

    led_pattern_gen #(.CLK_HZ(64), .TICK_HZ(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .resin_n(resin_n), .pwr_en(pwr_en),
        .rails_good(rails_good), .por_done(por_done), .boot_sd(boot_sd),
        .led_sel(led_sel), .gpio_led(gpio_led), .phy_led0(phy_led0),
        .phy_led1(phy_led1), .led_status(led_status), .led_user(led_user)
    );

    // Clock edges since reset release
    always @(posedge clk) begin
        if (!rst_n) ecount <= 0;
        else        ecount <= ecount + 1;
    end

    function automatic logic f_status(int ph);
        if (!resin_n)    return 1'b1;
        if (!pwr_en)     return (ph % 32) < 4;
        if (!rails_good) return 1'b1;
        if (boot_sd)     return (ph % 16) < 8;
        return (ph % 4) < 2;
    endfunction

    function automatic logic f_user();
        if (!resin_n)    return 1'b1;
        if (!pwr_en)     return 1'b1;
        if (!rails_good) return 1'b0;
        if (!por_done)   return gpio_led;
        if (led_sel == 4'd1) return phy_led0;
        if (led_sel == 4'd2) return phy_led1;
        return gpio_led;
    endfunction

    function automatic string f_tag();
        if (!resin_n)    return "R2";
        if (!pwr_en)     return "R3";
        if (!rails_good) return "R4";
        if (!por_done)   return boot_sd ? "R6/R7" : "R5/R7";
        if (led_sel > 4'd2) return boot_sd ? "R6/R9" : "R5/R9";
        return boot_sd ? "R6/R8" : "R5/R8";
    endfunction

    // Compute the expectation for the coming edge from the held inputs
    task automatic arm();
        int ph;
        ph = (ecount / DIV) % 32;
        exp_s = f_status(ph);
        exp_u = f_user();
        exp_tag = f_tag();
    endtask

    task automatic check(string tag, logic act_s, logic act_u, logic es, logic eu);
        checks++;
        if (act_s !== es || act_u !== eu) begin
            errors++;
            $display("FAIL %s: status=%b user=%b expected status=%b user=%b (t=%0t)",
                     tag, act_s, act_u, es, eu, $time);
        end
    endtask

    task automatic step();
        arm();
        @(negedge clk);
        check(exp_tag, led_status, led_user, exp_s, exp_u);
    endtask

    task automatic randomize_inputs();
        resin_n    = ($urandom % 10) != 0;
        pwr_en     = ($urandom % 7) != 0;
        rails_good = ($urandom % 6) != 0;
        por_done   = ($urandom % 3) != 0;
        boot_sd    = $urandom % 2;
        led_sel    = (($urandom % 5) < 3) ? 4'($urandom % 3) : 4'($urandom);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", led_status, led_user, 1'b0, 1'b0);
        rst_n = 1'b1;
        // Directed: SPI run, default mapping, two full periods (R5, R7)
        por_done = 1'b0; led_sel = 4'd1;
        for (int i = 0; i < 260; i++) begin
            gpio_led = $urandom; phy_led0 = $urandom; phy_led1 = $urandom;
            step();
        end
        // Directed: SD run with remap selects phy1 (R6, R8)
        por_done = 1'b1; boot_sd = 1'b1; led_sel = 4'd2;
        for (int i = 0; i < 140; i++) begin
            phy_led1 = $urandom; gpio_led = $urandom;
            step();
        end
        // Directed: power-down duty (R3), then rails off (R4)
        pwr_en = 1'b0;
        for (int i = 0; i < 140; i++) step();
        pwr_en = 1'b1; rails_good = 1'b0;
        for (int i = 0; i < 20; i++) step();
        // R1: mid-run reset restarts the phase
        rails_good = 1'b1; boot_sd = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", led_status, led_user, 1'b0, 1'b0);
        rst_n = 1'b1;
        for (int i = 0; i < 40; i++) step();
        // Random phase: inputs change every 1..8 cycles
        for (int i = 0; i < 600; i++) begin
            int hold;
            randomize_inputs();
            hold = 1 + ($urandom % 8);
            for (int k = 0; k < hold; k++) begin
                gpio_led = $urandom; phy_led0 = $urandom; phy_led1 = $urandom;
                step();
            end
        end
        done = 1'b1;
    end

    // Watchdog and summary
    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            end
        join_any
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule